// File: doc/BRIEF.md
# Embedded Controller Host Command Port

This block is the device end of a two-port mailbox through which a host reaches an embedded controller's internal byte-addressed register space. One port carries data bytes. The other port takes command bytes when written and returns a status byte when read. The host issues a command byte, then sends address and data bytes on the data port. The block turns each complete sequence into one access on a simple synchronous memory port. For a read, it posts the fetched byte back in its output buffer.

Two handshake flags pace the host. The input-full flag is set while an accepted byte has not yet been consumed. The output-full flag is set while a byte waits for the host to read it. Two more commands switch a burst-mode flag on and off. A query command answers with a zero byte because no events are pending. A command byte that arrives in the middle of a sequence abandons that sequence.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 and no memory access is issued.
- R2: A host write accepted while input-full is clear sets input-full (status bit 1). It also sets status bit 3 to 1 for the command port (select high) or 0 for the data port (select low). Both are visible in the cycle after the write.
- R3: Input-full stays set for exactly PROC_DLY (default 2) cycles after an accepted write, then clears.
- R4: A host write presented while input-full is set is dropped. Status bit 3 and the sequence state are unchanged, and no memory access follows from it.
- R5: Command 0x80 followed by an address byte on the data port gives one memory read of that address. The read request is high PROC_DLY cycles after the address write. Output-full (status bit 0) sets two cycles later, and the data port then returns the stored byte.
- R6: Command 0x81, then an address byte, then a data byte gives exactly one memory write cycle with that address and data. It starts PROC_DLY cycles after the data byte is written.
- R7: A host read of the data port clears output-full. A host read of the status port leaves it set.
- R8: Command 0x84 loads 0x00 into the output buffer and sets output-full PROC_DLY cycles after the command write.
- R9: Command 0x82 sets the burst flag (status bit 4) and command 0x83 clears it.
- R10: A command byte received mid-sequence abandons the pending sequence, so a partial write never reaches memory.
- R11: A data byte with no sequence pending, or any unknown command byte, causes no memory access and leaves output-full unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per byte |
| host_rd_i | input | 1 | Host read strobe |
| host_sel_i | input | 1 | Port select: 1 command/status, 0 data |
| host_wdata_i | input | 8 | Byte written by the host |
| host_rdata_o | output | 8 | Status byte or output buffer, chosen by host_sel_i |
| mem_req_o | output | 1 | Register-space access request, one cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Register address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |

## Verification
The bench counts cycles from the posedge that accepts a host write. Input-full must still be high one and two half-cycles after that edge and low at PROC_DLY plus a half. A memory request must be present at PROC_DLY plus a half after the final byte of a sequence. Output-full must follow two cycles after a read request. The bench samples each result on the falling edge at that offset and also checks the falling edge just before it, so a design that is early or late by one cycle is caught. A memory model inside the bench answers with a one-cycle latency, and a reference copy of the register space supplies the expected read values. These cover directed corner cases and a seeded random mix of reads and writes.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;
  localparam int STB_OBF   = 0;
  localparam int STB_IBF   = 1;
  localparam int STB_CMD   = 3;
  localparam int STB_BURST = 4;

  typedef logic [7:0] byte_t;

  typedef enum logic [7:0] {
    OP_READ      = 8'h80,
    OP_WRITE     = 8'h81,
    OP_BURST_ON  = 8'h82,
    OP_BURST_OFF = 8'h83,
    OP_QUERY     = 8'h84
  } ec_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD_ADDR,
    S_WR_ADDR,
    S_WR_DATA
  } ec_state_e;
endpackage

// File: rtl/ec_in_latch.sv
module ec_in_latch
  import ec_host_pkg::*;
#(
  parameter int PROC_DLY = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  logic  sel_i,
  input  byte_t wdata_i,
  output logic  ibf_o,
  output logic  is_cmd_o,
  output byte_t byte_o,
  output logic  take_o
);
  localparam int CW = $clog2(PROC_DLY + 1) + 1;

  logic          ibf_q, cmd_q;
  byte_t         byte_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = wr_i & ~ibf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      byte_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      ibf_q  <= 1'b1;
      cmd_q  <= sel_i;
      byte_q <= wdata_i;
      cnt_q  <= CW'(PROC_DLY);
    end else if (ibf_q) begin
      if (cnt_q == CW'(1)) ibf_q <= 1'b0;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign ibf_o    = ibf_q;
  assign is_cmd_o = cmd_q;
  assign byte_o   = byte_q;
  assign take_o   = ibf_q & (cnt_q == CW'(1));

  // cycles input-full has been high, for the bounded-window check
  logic [CW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt_q <= '0;
    else if (!ibf_q) hi_cnt_q <= '0;
    else             hi_cnt_q <= hi_cnt_q + CW'(1);
  end

  a_r3_ibf_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf_q |-> (hi_cnt_q < CW'(PROC_DLY)));

  a_r4_busy_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ibf_q) |=> ($stable(byte_q) && $stable(cmd_q)));
endmodule

// File: rtl/ec_seq.sv
module ec_seq
  import ec_host_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          is_cmd_i,
  input  byte_t         byte_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output byte_t         mem_wdata_o,
  output logic          rd_done_o,
  output logic          query_o,
  output logic          burst_o
);
  ec_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic          req_q, we_q, rd_wait_q, burst_q;
  logic [AW-1:0] maddr_q;
  byte_t         wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      maddr_q   <= '0;
      wdata_q   <= '0;
      rd_wait_q <= 1'b0;
      burst_q   <= 1'b0;
    end else begin
      req_q     <= 1'b0;
      rd_wait_q <= req_q & ~we_q;
      if (take_i) begin
        if (is_cmd_i) begin
          state_q <= S_IDLE;  // any command abandons a pending sequence
          case (byte_i)
            OP_READ:      state_q <= S_RD_ADDR;
            OP_WRITE:     state_q <= S_WR_ADDR;
            OP_BURST_ON:  burst_q <= 1'b1;
            OP_BURST_OFF: burst_q <= 1'b0;
            default: ;
          endcase
        end else begin
          case (state_q)
            S_RD_ADDR: begin
              req_q   <= 1'b1;
              we_q    <= 1'b0;
              maddr_q <= byte_i[AW-1:0];
              state_q <= S_IDLE;
            end
            S_WR_ADDR: begin
              addr_q  <= byte_i[AW-1:0];
              state_q <= S_WR_DATA;
            end
            S_WR_DATA: begin
              req_q   <= 1'b1;
              we_q    <= 1'b1;
              maddr_q <= addr_q;
              wdata_q <= byte_i;
              state_q <= S_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = wdata_q;
  assign rd_done_o   = rd_wait_q;
  assign query_o     = take_i & is_cmd_i & (byte_i == OP_QUERY);
  assign burst_o     = burst_q;

  a_r6_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r11_idle_data_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !is_cmd_i && state_q == S_IDLE) |=> !mem_req_o);

  a_r10_cmd_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && is_cmd_i) |=> !mem_req_o);
endmodule

// File: rtl/ec_out_buf.sv
module ec_out_buf
  import ec_host_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_done_i,
  input  byte_t rdata_i,
  input  logic  query_i,
  input  logic  host_rd_i,
  output logic  obf_o,
  output byte_t byte_o
);
  logic  obf_q;
  byte_t byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_q  <= 1'b0;
      byte_q <= '0;
    end else if (rd_done_i) begin
      obf_q  <= 1'b1;
      byte_q <= rdata_i;
    end else if (query_i) begin
      obf_q  <= 1'b1;
      byte_q <= '0;
    end else if (host_rd_i) begin
      obf_q  <= 1'b0;
    end
  end

  assign obf_o  = obf_q;
  assign byte_o = byte_q;

  a_r7_host_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !rd_done_i && !query_i) |=> !obf_o);

  a_r8_query_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_i && !rd_done_i) |=> (obf_o && byte_o == 8'h00));
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_host_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PROC_DLY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic          host_sel_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  logic  ibf, is_cmd, take, rd_done, query, burst, obf;
  byte_t in_byte, out_byte, status;

  ec_in_latch #(.PROC_DLY(PROC_DLY)) u_in (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .sel_i(host_sel_i), .wdata_i(host_wdata_i),
    .ibf_o(ibf), .is_cmd_o(is_cmd), .byte_o(in_byte), .take_o(take)
  );

  ec_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .take_i(take), .is_cmd_i(is_cmd), .byte_i(in_byte),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .rd_done_o(rd_done), .query_o(query), .burst_o(burst)
  );

  ec_out_buf u_out (
    .clk_i, .rst_ni,
    .rd_done_i(rd_done), .rdata_i(mem_rdata_i), .query_i(query),
    .host_rd_i(host_rd_i & ~host_sel_i),
    .obf_o(obf), .byte_o(out_byte)
  );

  always_comb begin
    status            = '0;
    status[STB_OBF]   = obf;
    status[STB_IBF]   = ibf;
    status[STB_CMD]   = is_cmd;
    status[STB_BURST] = burst;
  end

  assign host_rdata_o = host_sel_i ? status : out_byte;

  a_r2_write_sets_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !ibf) |=> (ibf && is_cmd == $past(host_sel_i)));

  a_r5_read_posts_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> ##1 obf);
endmodule

// File: tb/ec_host_port_tb_top.sv
module ec_host_port_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int DLY   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0, acc_cnt = 0;
  bit done = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  always #(CLK_P/2) clk = ~clk;

  ec_host_port #(.AW(AW), .PROC_DLY(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // register space model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] exp_status(bit obf, bit ibf, bit cmd, bit burst);
    return {3'b000, burst, cmd, 1'b0, ibf, obf};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    host_sel = sel;
    #1 v = host_rdata;
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_clear();
    logic [7:0] s;
    for (int i = 0; i < 8; i++) begin
      peek(1'b1, s);
      if (!s[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] s;
    host_write(1'b1, 8'h80); wait_clear();
    host_write(1'b0, a);
    repeat (DLY) @(negedge clk);
    chk("R5 read req", {mem_req, mem_we, 8'(mem_addr)}, {1'b1, 1'b0, a});
    @(negedge clk);
    peek(1'b1, s); chk("R5 obf not early", 32'(s[0]), 32'd0);
    @(negedge clk);
    peek(1'b1, s); chk("R5 obf set", 32'(s[0]), 32'd1);
    host_read(1'b0, v);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    host_write(1'b1, 8'h81); wait_clear();
    host_write(1'b0, a); wait_clear();
    host_write(1'b0, d);
    repeat (DLY) @(negedge clk);
    chk("R6 write req", {mem_req, mem_we, 8'(mem_addr), mem_wdata}, {1'b1, 1'b1, a, d});
    @(negedge clk);
    chk("R6 single cycle", 32'(mem_req), 32'd0);
    ref_mem[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v;
    int acc0;
    void'($urandom(32'd20240917));
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      ref_mem[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    peek(1'b1, s);
    chk("R1 status", s, 8'h00);
    chk("R1 no req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 command port
    host_write(1'b1, 8'h83);
    peek(1'b1, s); chk("R2 cmd write", s, exp_status(0, 1, 1, 0));
    @(negedge clk);
    peek(1'b1, s); chk("R3 ibf held", s, exp_status(0, 1, 1, 0));
    @(negedge clk);
    peek(1'b1, s); chk("R3 ibf cleared", s, exp_status(0, 0, 1, 0));

    // R2/R11 data byte with nothing pending
    acc0 = acc_cnt;
    host_write(1'b0, 8'h12);
    peek(1'b1, s); chk("R2 data write", s, exp_status(0, 1, 0, 0));
    repeat (4) @(negedge clk);
    chk("R11 idle data no access", acc_cnt, acc0);
    peek(1'b1, s); chk("R11 obf unchanged", s, exp_status(0, 0, 0, 0));

    // R11 unknown command then data
    host_write(1'b1, 8'h90); wait_clear();
    host_write(1'b0, 8'h33);
    repeat (4) @(negedge clk);
    chk("R11 unknown cmd no access", acc_cnt, acc0);

    // R9 burst
    host_write(1'b1, 8'h82); wait_clear();
    peek(1'b1, s); chk("R9 burst on", s, exp_status(0, 0, 1, 1));
    host_write(1'b1, 8'h83); wait_clear();
    peek(1'b1, s); chk("R9 burst off", s, exp_status(0, 0, 1, 0));

    // R8 query, R7 status read keeps obf, data read clears
    host_write(1'b1, 8'h84);
    @(negedge clk);
    peek(1'b1, s); chk("R8 obf not early", 32'(s[0]), 32'd0);
    @(negedge clk);
    peek(1'b1, s); chk("R8 query obf", s, exp_status(1, 0, 1, 0));
    host_read(1'b1, s);
    peek(1'b1, s); chk("R7 status read keeps obf", 32'(s[0]), 32'd1);
    host_read(1'b0, v); chk("R8 query data", v, 8'h00);
    peek(1'b1, s); chk("R7 data read clears obf", 32'(s[0]), 32'd0);

    // R4 write during input-full dropped
    acc0 = acc_cnt;
    host_write(1'b1, 8'h80);
    host_write(1'b0, 8'h55);
    wait_clear();
    peek(1'b1, s); chk("R4 cmd flag kept", s, exp_status(0, 0, 1, 0));
    repeat (4) @(negedge clk);
    chk("R4 no access", acc_cnt, acc0);
    host_write(1'b0, 8'h20);
    repeat (4) @(negedge clk);
    host_read(1'b0, v); chk("R4 R5 read after drop", v, ref_mem[8'h20]);

    // R6 write then readback
    do_write(8'h40, 8'hA5);
    do_read(8'h40, v); chk("R6 readback", v, 8'hA5);

    // R10 abort partial write
    acc0 = acc_cnt;
    host_write(1'b1, 8'h81); wait_clear();
    host_write(1'b0, 8'h50); wait_clear();
    host_write(1'b1, 8'h80); wait_clear();
    host_write(1'b0, 8'h51);
    repeat (4) @(negedge clk);
    chk("R10 one access only", acc_cnt, acc0 + 1);
    host_read(1'b0, v); chk("R10 new read data", v, ref_mem[8'h51]);
    do_read(8'h50, v); chk("R10 target untouched", v, ref_mem[8'h50]);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, d;
      a = 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 2) do_write(a, d);
      else begin
        do_read(a, v);
        chk("R5 random read", v, ref_mem[a]);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule